// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer with Paired Byte Clocks

This block sits behind a clock-and-data-recovery stage. It takes one retimed serial bit per bit-clock cycle and rebuilds 10-bit words. The first bit received becomes bit 0 of the word. A 10-bit sliding window is searched for the positive-disparity comma prefix. When alignment is enabled, a comma found at any offset moves the word boundary so that the comma starts a word. When alignment is disabled, words stay framed on the boundary that has been running since reset.

Two byte clocks are produced from the bit clock. They are complementary and run at one twentieth of the bit rate. Successive words are presented on their alternating rising edges, and comma words land on the rising edge of `byte_clk1`. When a comma moves the boundary, or puts a comma on the wrong clock, the clocks are held at their current level until a later boundary is reached. No level ever lasts less than one word time. In every case the second comma arrives aligned. A one-cycle `sync_pulse` marks each detected comma, but only while alignment is enabled. All outputs are registers clocked by the bit clock.

Top module: `comma_deser`

## Requirements
- R1: The bit sampled first within a word appears at `word_out[0]` (least significant), and later bits appear in increasing bit positions.
- R2: With `align_en` high, a window whose first seven bits in arrival order are 0,0,1,1,1,1,1 (low seven bits of the LSB-first word equal 7'b1111100) is taken as a comma. The word boundary is restarted so that this window forms one word.
- R3: `byte_clk0` is always the complement of `byte_clk1`. In steady state each level lasts exactly 10 bit-clock cycles, and each word is presented on one rising edge, alternating between the two clocks.
- R4: No high or low level of either byte clock lasts fewer than 10 bit-clock cycles, including during realignment.
- R5: With alignment enabled, a comma word is never presented on a rising edge of `byte_clk0`. The second comma of a stream of comma-plus-data ordered sets (and every later one) is presented on a rising edge of `byte_clk1`.
- R6: `sync_pulse` is high for one cycle per detected comma, and only when `align_en` was high in the cycle the comma completed.
- R7: With `align_en` low, commas change neither the framing nor the clocks. Word n is made of bits 10n..10n+9 counted from reset release, every clock level lasts 10 cycles, and `sync_pulse` stays low.
- R8: `word_out` changes only in the cycle in which one of the byte clocks rises.
- R9: During reset, `word_out` is 0, `byte_clk1` is 0, `byte_clk0` is 1 and `sync_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Retimed serial data bit, one per clock |
| align_en | input | 1 | High enables comma search and realignment |
| word_out | output | 10 | Rebuilt word, bit 0 received first |
| byte_clk1 | output | 1 | Byte clock that rises with comma words |
| byte_clk0 | output | 1 | Complementary byte clock |
| sync_pulse | output | 1 | One-cycle comma detection flag |

## Verification
Comma-plus-data ordered sets are sent after 0, 3 and 7 junk bits. This separates an already aligned boundary from boundaries that need a short or a long stretch, and either byte-clock polarity at the first comma. A mid-stream slip of three bits shows that the block can realign from a running lock and still never shortens a clock level. The same misaligned stream with alignment disabled is compared bit for bit against framing counted from reset. This confirms that commas are ignored and that no sync pulse appears. Data words carry a sequence index in their bits, so dropped, repeated or bit-reversed words show up as decode or sequence errors.

// File: rtl/cds_pkg.sv
package cds_pkg;
    localparam int WORD_W    = 10;
    localparam int COMMA_LEN = 7;
    localparam int CNT_W     = $clog2(WORD_W);
    localparam int PH_W      = $clog2(WORD_W);
    localparam logic [COMMA_LEN-1:0] COMMA_PAT = 7'b1111100;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  boundary;
        logic  comma;
        word_t word;
    } frame_ev_t;

    function automatic logic is_comma(input word_t w);
        return w[COMMA_LEN-1:0] == COMMA_PAT;
    endfunction
endpackage

// File: rtl/cds_framer.sv
module cds_framer
    import cds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_bit,
    input  logic      align_en,
    output frame_ev_t ev
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    word_t            win_q;
    logic [CNT_W-1:0] cnt_q;
    word_t            win_nx;
    logic             hit;

    always_comb begin
        win_nx      = {ser_bit, win_q[WORD_W-1:1]};
        hit         = align_en && is_comma(win_nx);
        ev.word     = win_nx;
        ev.comma    = hit;
        ev.boundary = hit || (cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_nx;
            if (ev.boundary) cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cds_clkgen.sv
module cds_clkgen
    import cds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  frame_ev_t ev,
    output word_t     word_out,
    output logic      byte_clk1,
    output logic      byte_clk0,
    output logic      sync_pulse
);
    localparam logic [PH_W-1:0] PH_FULL = PH_W'(WORD_W - 1);

    logic            sel_q;
    logic            par_q;
    logic [PH_W-1:0] ph_q;
    word_t           word_q;
    logic            sync_q;
    logic            par_nx;
    logic            step;

    // Parity says which clock the current word belongs to; commas force clk1.
    always_comb begin
        par_nx = ev.comma ? 1'b1 : ~par_q;
        step   = ev.boundary && (ph_q == PH_FULL) && (sel_q != par_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            par_q  <= 1'b0;
            ph_q   <= PH_FULL;
            word_q <= '0;
            sync_q <= 1'b0;
        end else begin
            sync_q <= ev.comma;
            if (ev.boundary) par_q <= par_nx;
            if (step) begin
                sel_q  <= ~sel_q;
                word_q <= ev.word;
                ph_q   <= '0;
            end else if (ph_q != PH_FULL) begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign word_out   = word_q;
    assign byte_clk1  = sel_q;
    assign byte_clk0  = ~sel_q;
    assign sync_pulse = sync_q;
endmodule

// File: rtl/comma_deser.sv
module comma_deser
    import cds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    input  logic              align_en,
    output logic [WORD_W-1:0] word_out,
    output logic              byte_clk1,
    output logic              byte_clk0,
    output logic              sync_pulse
);
    frame_ev_t ev;

    cds_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .ser_bit  (ser_bit),
        .align_en (align_en),
        .ev       (ev)
    );

    cds_clkgen u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .word_out   (word_out),
        .byte_clk1  (byte_clk1),
        .byte_clk0  (byte_clk0),
        .sync_pulse (sync_pulse)
    );
endmodule

// File: rtl/cds_chk.sv
module cds_chk
    import cds_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              align_en,
    input logic [WORD_W-1:0] word_out,
    input logic              byte_clk1,
    input logic              byte_clk0,
    input logic              sync_pulse
);
    localparam int RUN_W = $clog2(WORD_W + 1);

    logic             prev_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= RUN_W'(WORD_W);
        end else begin
            prev_q <= byte_clk1;
            if (byte_clk1 != prev_q)         run_q <= RUN_W'(1);
            else if (run_q != RUN_W'(WORD_W)) run_q <= run_q + 1'b1;
        end
    end

    a_r4_min_phase: assert property (@(posedge clk) disable iff (rst)
        (byte_clk1 != prev_q) |-> (run_q == RUN_W'(WORD_W)));

    a_r5_no_comma_on_clk0: assert property (@(posedge clk) disable iff (rst)
        ($rose(byte_clk0) && $past(align_en)) |-> !is_comma(word_out));

    a_r6_sync_gated: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> $past(align_en));

    a_r8_word_on_edge: assert property (@(posedge clk) disable iff (rst)
        (!$rose(byte_clk1) && !$rose(byte_clk0)) |-> $stable(word_out));
endmodule

bind comma_deser cds_chk u_cds_chk (
    .clk        (clk),
    .rst        (rst),
    .align_en   (align_en),
    .word_out   (word_out),
    .byte_clk1  (byte_clk1),
    .byte_clk0  (byte_clk0),
    .sync_pulse (sync_pulse)
);

// File: tb/sim_comma_deser.sv
`timescale 1ns/1ps
module sim_comma_deser;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_bit = 1'b0;
    logic       align_en = 1'b1;
    logic [9:0] word_out;
    logic       byte_clk1, byte_clk0, sync_pulse;

    comma_deser u0 (
        .clk(clk), .rst(rst), .ser_bit(ser_bit), .align_en(align_en),
        .word_out(word_out), .byte_clk1(byte_clk1), .byte_clk0(byte_clk0),
        .sync_pulse(sync_pulse)
    );

    always #5 clk = ~clk;

    localparam logic [9:0] COMMA_W = 10'h17C;

    int total = 0;
    int fails = 0;

    // monitor state
    int   mode = 0;           // 0 aligned, 1 disabled
    logic prev1 = 1'b0;
    logic [9:0] prev_word = '0;
    int   len = 0;
    bit   seen_edge = 0;
    int   phase_bad = 0, phase_long = 0, comp_err = 0, stable_err = 0;
    int   ncomma = 0, comma_on0 = 0, nsync = 0;
    int   data_good = 0, data_bad = 0, prev_idx = 0;
    bit   have_prev = 0, last1_comma = 0;
    int   dis_good = 0, dis_bad = 0, nword = 0;
    logic blog [0:8191];
    int   nlog = 0;

    function automatic logic [9:0] dat(input int i);
        logic [3:0] k;
        k = 4'(i);
        return {1'b0, k[3], 1'b0, k[2], 1'b1, k[1], 1'b0, k[0], 1'b0, 1'b1};
    endfunction

    function automatic int undat(input logic [9:0] w);
        return int'({w[8], w[6], w[4], w[2]});
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            prev1 = 1'b0; len = 0; seen_edge = 0; prev_word = '0;
        end else begin
            logic r1, r0;
            r1 = !prev1 && byte_clk1;
            r0 = prev1 && !byte_clk1;
            if (byte_clk0 !== ~byte_clk1) comp_err++;
            if (!(r1 || r0) && word_out !== prev_word) stable_err++;
            if (r1 || r0) begin
                if (seen_edge) begin
                    if (len < 10) phase_bad++;
                    if (len > 10) phase_long++;
                end
                seen_edge = 1; len = 1;
            end else begin
                len++;
            end
            if (mode == 0) begin
                if (r1) begin
                    last1_comma = (word_out == COMMA_W);
                    if (last1_comma) ncomma++;
                end
                if (r0) begin
                    if (word_out[6:0] == 7'b1111100) comma_on0++;
                    else if (ncomma >= 2 && last1_comma) begin
                        int idx;
                        idx = undat(word_out);
                        if (word_out != dat(idx)) data_bad++;
                        else if (have_prev && idx != ((prev_idx + 1) % 16)) data_bad++;
                        else data_good++;
                        prev_idx = idx; have_prev = 1;
                    end
                    last1_comma = 0;
                end
            end else if (r1 || r0) begin
                logic [9:0] e;
                for (int b = 0; b < 10; b++) e[b] = blog[10*nword + b];
                if (word_out === e) dis_good++; else dis_bad++;
                nword++;
            end
            if (sync_pulse) nsync++;
            prev1 = byte_clk1;
            prev_word = word_out;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        phase_bad = 0; phase_long = 0; comp_err = 0; stable_err = 0;
        ncomma = 0; comma_on0 = 0; nsync = 0; data_good = 0; data_bad = 0;
        have_prev = 0; last1_comma = 0; dis_good = 0; dis_bad = 0; nword = 0;
        nlog = 0;
    endtask

    task automatic do_reset(input logic en, input int md);
        rst = 1'b1; align_en = en; ser_bit = 1'b0; mode = md;
        repeat (3) @(negedge clk);
        clear_mon();
        rst = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        ser_bit = b;
        blog[nlog] = b;
        nlog++;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) send_bit(1'(i % 2 == 0));
    endtask

    task automatic t_reset_state();
        rst = 1'b1; align_en = 1'b1; ser_bit = 1'b1;
        repeat (3) @(negedge clk);
        check(word_out == 10'd0, "R9 word_out in reset", int'(word_out), 0);
        check(byte_clk1 == 1'b0 && byte_clk0 == 1'b1, "R9 byte clocks in reset",
              int'({byte_clk1, byte_clk0}), 1);
        check(sync_pulse == 1'b0, "R9 sync in reset", int'(sync_pulse), 0);
    endtask

    task automatic t_aligned(input int off, input int nsets);
        do_reset(1'b1, 0);
        send_junk(off);
        for (int s = 0; s < nsets; s++) begin
            send_word(COMMA_W);
            send_word(dat(s));
        end
        send_junk(40);
        check(phase_bad == 0, "R4 no short clock level", phase_bad, 0);
        check(comp_err == 0, "R3 clocks complementary", comp_err, 0);
        check(phase_long <= 3, "R3 steady 10-cycle levels", phase_long, 3);
        check(comma_on0 == 0, "R5 no comma on byte_clk0", comma_on0, 0);
        check(ncomma >= nsets - 1, "R5 commas on byte_clk1 from second set", ncomma, nsets - 1);
        check(data_bad == 0, "R1 R2 data words after alignment", data_bad, 0);
        check(data_good >= nsets - 2, "R2 aligned data count", data_good, nsets - 2);
        check(nsync == nsets, "R6 one sync per comma", nsync, nsets);
        check(stable_err == 0, "R8 word changes only at rising edge", stable_err, 0);
    endtask

    task automatic t_slip();
        int sb;
        do_reset(1'b1, 0);
        send_junk(2);
        for (int s = 0; s < 6; s++) begin send_word(COMMA_W); send_word(dat(s)); end
        send_bit(1'b0);
        ncomma = 0; have_prev = 0; last1_comma = 0; sb = data_good;
        send_bit(1'b1); send_bit(1'b0);
        for (int s = 0; s < 8; s++) begin send_word(COMMA_W); send_word(dat(s + 6)); end
        send_junk(40);
        check(phase_bad == 0, "R4 no short level across slip", phase_bad, 0);
        check(ncomma >= 7, "R5 relock after slip", ncomma, 7);
        check(data_bad == 0, "R2 data after slip", data_bad, 0);
        check(data_good - sb >= 6, "R2 data count after slip", data_good - sb, 6);
        check(nsync == 14, "R6 sync count across slip", nsync, 14);
        check(comma_on0 == 0, "R5 no comma on byte_clk0 after slip", comma_on0, 0);
    endtask

    task automatic t_disabled();
        do_reset(1'b0, 1);
        send_junk(3);
        for (int s = 0; s < 6; s++) begin send_word(COMMA_W); send_word(dat(s + 3)); end
        send_junk(27);
        check(dis_bad == 0, "R7 R1 framing from reset", dis_bad, 0);
        check(dis_good >= (nlog / 10) - 1, "R7 word count", dis_good, (nlog / 10) - 1);
        check(nsync == 0, "R6 R7 no sync when disabled", nsync, 0);
        check(phase_long == 0 && phase_bad == 0, "R7 clocks untouched by commas",
              phase_long + phase_bad, 0);
        check(stable_err == 0, "R8 word stable between edges", stable_err, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_aligned(0, 8);
        t_aligned(3, 8);
        t_aligned(7, 10);
        t_slip();
        t_disabled();
        finish_run();
    end
endmodule